// File: doc/BRIEF.md
# Chained Operation Stream Pipeline

This block is a linear chain of execution stages that all work on one data stream. Only the head stage sees the incoming source words. Every later stage works on the word that the stage in front of it produced one cycle earlier. The tail stage drives the output stream. As a result, while the head works on source word *i*, stage *i* works on the *i*-th transform of the first source word. Each stage has its own operation and an 8-bit constant, so a single data stream passes through several independent instruction streams.

A pass is a burst of source words whose final word carries an end-of-pass marker. The marker travels down the chain with its word. Configuration is locked for the whole of a pass. Writes to the configuration port go into shadow registers at any time. They reach the working registers only while no pass is open, or in the cycle the marker leaves the tail. After the marked word has been accepted, the head takes no more input until the chain has drained. Backpressure at the output freezes every stage in the same cycle.

Top module: `chain_pipe`

## Requirements
- R1: After reset `out_valid` is low, `in_ready` is high, and every stage performs pass-through with constant 0, so a word comes out unchanged.
- R2: The output word equals the source word transformed by stage 0, then by stage 1, and so on up to stage N-1, in that order. Each stage uses its own operation and constant.
- R3: The operation codes are: 0 pass-through, 1 add constant, 2 subtract constant, 3 AND constant, 4 OR constant, 5 XOR constant, 6 shift left by the low log2(W) bits of the constant, 7 low W bits of the product with the constant. The constant is zero-extended and all arithmetic wraps modulo 2^W.
- R4: A source word accepted at clock edge E appears on `out_valid`/`out_data` right after edge E+N-1, and one word can be accepted in every cycle.
- R5: While `out_valid` is high and `out_ready` is low, `out_data`, `out_last` and `out_valid` hold, `in_ready` is low, and no word is lost or reordered.
- R6: A pass opens when its first word is accepted and closes when its marked word leaves the tail. A configuration write made while a pass is open has no effect on any word of that pass, and it applies to the next pass.
- R7: A configuration write (`cfg_we`, `cfg_sel`, `cfg_op`, `cfg_k`) made while no pass is open applies to the first word accepted after the write cycle.
- R8: Once a word with `in_last` high has been accepted, `in_ready` stays low until that word has been taken at the output.
- R9: `out_last` is high only on the output word that entered with `in_last` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Source word offered |
| in_ready | output | 1 | Head stage can accept |
| in_data | input | W | Source word |
| in_last | input | 1 | Source word ends the pass |
| out_valid | output | 1 | Tail word valid |
| out_ready | input | 1 | Consumer takes tail word |
| out_data | output | W | Result of the whole chain |
| out_last | output | 1 | Result ends the pass |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | log2(N) | Stage addressed by the write |
| cfg_op | input | 3 | Operation code for that stage |
| cfg_k | input | 8 | Constant for that stage |

## Verification
The bench checks the order in which the stages are applied by giving each stage an operation that does not commute with its neighbours. A chain wired in reverse order, or with a stage skipped, would then give a different word. It writes a stage's configuration in the middle of an open pass and expects the rest of that pass to use the old setting and the next pass to use the new one. A design that applied the write at once, or never applied it, would corrupt one of the two passes. It holds the output not-ready while words are in flight and expects the tail word to hold and nothing to be lost. A design that stalled only the tail stage would drop or duplicate words. It also measures the exact skew from input to output, and it checks that the head refuses input between the marked word and its exit.

// File: rtl/chain_pipe.sv
module chain_pipe #(
  parameter int W  = 16,
  parameter int N  = 4,
  parameter int KW = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int SW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_data,
  input  logic          in_last,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_data,
  output logic          out_last,
  input  logic          cfg_we,
  input  logic [IW-1:0] cfg_sel,
  input  logic [2:0]    cfg_op,
  input  logic [KW-1:0] cfg_k
);

  function automatic logic [W-1:0] alu(input logic [2:0] o, input logic [KW-1:0] k,
                                       input logic [W-1:0] x);
    logic [W-1:0] kx;
    kx = {{(W-KW){1'b0}}, k};
    case (o)
      3'd1:    return x + kx;
      3'd2:    return x - kx;
      3'd3:    return x & kx;
      3'd4:    return x | kx;
      3'd5:    return x ^ kx;
      3'd6:    return x << k[SW-1:0];
      3'd7:    return x * kx;
      default: return x;
    endcase
  endfunction

  logic [N-1:0] vld, lst;
  logic [W-1:0] dat [N];
  logic adv, start, done, load, pass_on, closing;

  assign adv      = ~(vld[N-1] & ~out_ready);
  assign in_ready = adv & ~closing;
  assign start    = in_valid & in_ready;
  assign done     = vld[N-1] & lst[N-1] & out_ready;
  assign load     = done | (~pass_on & ~start);

  assign out_valid = vld[N-1];
  assign out_data  = dat[N-1];
  assign out_last  = lst[N-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pass_on <= 1'b0;
      closing <= 1'b0;
    end else begin
      pass_on <= (pass_on & ~done) | start;
      closing <= (closing & ~done) | (start & in_last);
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_st
    logic [W-1:0]  src, d_q;
    logic          sv, sl, v_q, l_q;
    logic [2:0]    op_sh, op_act, op_n;
    logic [KW-1:0] k_sh, k_act, k_n;
    logic          hit;

    if (i == 0) begin : g_head
      assign src = in_data;
      assign sv  = start;
      assign sl  = in_last;
    end else begin : g_tail
      assign src = dat[i-1];
      assign sv  = vld[i-1];
      assign sl  = lst[i-1];
    end

    assign hit  = cfg_we && (cfg_sel == IW'(i));
    assign op_n = hit ? cfg_op : op_sh;
    assign k_n  = hit ? cfg_k  : k_sh;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q    <= 1'b0;
        l_q    <= 1'b0;
        d_q    <= '0;
        op_sh  <= '0;
        op_act <= '0;
        k_sh   <= '0;
        k_act  <= '0;
      end else begin
        if (adv) begin
          v_q <= sv;
          if (sv) begin
            d_q <= alu(op_act, k_act, src);
            l_q <= sl;
          end
        end
        op_sh <= op_n;
        k_sh  <= k_n;
        if (load) begin
          op_act <= op_n;
          k_act  <= k_n;
        end
      end
    end

    assign vld[i] = v_q;
    assign lst[i] = l_q;
    assign dat[i] = d_q;
  end

endmodule

// File: rtl/chain_pipe_chk.sv
module chain_pipe_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         in_last,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_data,
  input logic         out_last
);
  logic [7:0] inflight;
  logic       tail_pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inflight     <= '0;
      tail_pending <= 1'b0;
    end else begin
      inflight <= inflight + 8'(in_valid && in_ready) - 8'(out_valid && out_ready);
      if (in_valid && in_ready && in_last) tail_pending <= 1'b1;
      else if (out_valid && out_ready && out_last) tail_pending <= 1'b0;
    end
  end

  p_empty_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    inflight == 8'd0 |-> !out_valid);
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));
  p_stall_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
  p_closed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tail_pending |-> !in_ready);
  p_last_alone_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_last |-> inflight == 8'd1);
endmodule

bind chain_pipe chain_pipe_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_last(in_last), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_last(out_last)
);

// File: tb/chain_pipe_test.sv
module chain_pipe_test;
  localparam int W = 16, N = 4;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_last = 0, out_ready = 1, cfg_we = 0;
  logic [W-1:0] in_data = '0;
  logic [1:0] cfg_sel = '0;
  logic [2:0] cfg_op = '0;
  logic [7:0] cfg_k = '0;
  logic in_ready, out_valid, out_last;
  logic [W-1:0] out_data;

  chain_pipe #(.W(W), .N(N)) uut (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  logic [2:0] m_op [N];
  logic [7:0] m_k  [N];
  logic [W-1:0] rec_d [64];
  logic rec_l [64];
  int rec_n = 0;
  logic [W-1:0] exp_d [16];
  int exp_n = 0;

  initial forever begin
    @(posedge clk); #8;
    if (out_valid && out_ready && rec_n < 64) begin
      rec_d[rec_n] = out_data; rec_l[rec_n] = out_last; rec_n++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [W-1:0] f1(logic [2:0] o, logic [7:0] k, logic [W-1:0] x);
    logic [W-1:0] kx = {8'h00, k};
    logic [2*W-1:0] p;
    case (o)
      1: return x + kx;
      2: return x - kx;
      3: return x & kx;
      4: return x | kx;
      5: return x ^ kx;
      6: return x << k[3:0];
      7: begin p = x * kx; return p[W-1:0]; end
      default: return x;
    endcase
  endfunction

  function automatic logic [W-1:0] chain(logic [W-1:0] x);
    logic [W-1:0] y = x;
    for (int i = 0; i < N; i++) y = f1(m_op[i], m_k[i], y);
    return y;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic cfg(int s, logic [2:0] o, logic [7:0] k, bit model);
    cfg_we = 1; cfg_sel = 2'(s); cfg_op = o; cfg_k = k;
    tick();
    cfg_we = 0;
    if (model) begin m_op[s] = o; m_k[s] = k; end
  endtask

  task automatic send(logic [W-1:0] d, bit last);
    bit ok;
    in_valid = 1; in_data = d; in_last = last;
    forever begin
      #7 ok = in_ready;
      @(posedge clk); #1;
      if (ok) break;
    end
    in_valid = 0; in_last = 0;
  endtask

  task automatic push(logic [W-1:0] d, bit last);
    exp_d[exp_n] = chain(d); exp_n++;
    send(d, last);
  endtask

  task automatic clear(); rec_n = 0; exp_n = 0; endtask

  task automatic drain_cmp(string req);
    for (int t = 0; t < 200 && rec_n < exp_n; t++) tick();
    tick(); tick();
    chk(rec_n == exp_n, req, "result count", rec_n, exp_n);
    for (int i = 0; i < exp_n && i < rec_n; i++) begin
      chk(rec_d[i] == exp_d[i], req, $sformatf("word %0d", i), rec_d[i], exp_d[i]);
      chk(rec_l[i] == (i == exp_n - 1), "R9", $sformatf("marker %0d", i), rec_l[i], i == exp_n - 1);
    end
  endtask

  task automatic t_reset();
    chk(out_valid == 0, "R1", "out_valid after reset", out_valid, 0);
    chk(in_ready == 1, "R1", "in_ready after reset", in_ready, 1);
    clear();
    push(16'hBEEF, 1);
    drain_cmp("R1");
  endtask

  task automatic t_chain();
    cfg(0, 3'd1, 8'd3, 1); cfg(1, 3'd6, 8'd2, 1);
    cfg(2, 3'd5, 8'h0F, 1); cfg(3, 3'd2, 8'd1, 1);
    clear();
    push(16'h0000, 0); push(16'h0005, 0); push(16'hFFFE, 0);
    push(16'd100, 0); push(16'h1234, 1);
    drain_cmp("R2");
  endtask

  task automatic t_ops();
    cfg(0, 3'd7, 8'd7, 1); cfg(1, 3'd3, 8'hF0, 1);
    cfg(2, 3'd4, 8'h81, 1); cfg(3, 3'd0, 8'h55, 1);
    clear();
    push(16'h1111, 0); push(16'hFFFF, 0); push(16'h0123, 1);
    drain_cmp("R3");
  endtask

  task automatic t_latency();
    int k = 0;
    clear();
    push(16'h0042, 1);
    while (!out_valid && k < 20) begin tick(); k++; end
    chk(k == N - 1, "R4", "cycles from accept to output", k, N - 1);
    drain_cmp("R4");
  endtask

  task automatic t_stall();
    logic [W-1:0] held;
    clear();
    out_ready = 0;
    push(16'h0A0A, 0); push(16'h0B0B, 0);
    for (int i = 0; i < 6; i++) tick();
    held = out_data;
    chk(out_valid == 1, "R5", "valid held while stalled", out_valid, 1);
    chk(held == exp_d[0], "R5", "head word at tail", held, exp_d[0]);
    chk(in_ready == 0, "R5", "in_ready during stall", in_ready, 0);
    tick(); tick();
    chk(out_data == held, "R5", "data stable in stall", out_data, held);
    chk(rec_n == 0, "R5", "nothing taken in stall", rec_n, 0);
    out_ready = 1;
    push(16'h0C0C, 1);
    drain_cmp("R5");
  endtask

  task automatic t_lock();
    cfg(0, 3'd1, 8'd1, 1); cfg(1, 3'd5, 8'h33, 1);
    cfg(2, 3'd6, 8'd1, 1); cfg(3, 3'd2, 8'd2, 1);
    clear();
    push(16'h0100, 0);
    cfg(1, 3'd7, 8'd3, 0);
    push(16'h0200, 1);
    #6 chk(in_ready == 0, "R8", "in_ready after marker", in_ready, 0);
    #1 tick();
    drain_cmp("R6");
    m_op[1] = 3'd7; m_k[1] = 8'd3;
    clear();
    push(16'h0300, 1);
    drain_cmp("R6");
  endtask

  task automatic t_idle_write();
    clear();
    cfg(3, 3'd4, 8'h80, 1);
    push(16'h0007, 1);
    drain_cmp("R7");
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin m_op[i] = 0; m_k[i] = 0; end
    tick(); tick(); tick();
    rst_n = 1;
    tick();
    t_reset();
    t_chain();
    t_ops();
    t_latency();
    t_stall();
    t_lock();
    t_idle_write();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule